// File: doc/BRIEF.md
# Rotate Unit with Carry-Out

This block is the rotate stage of a 32-bit processor datapath. It either turns a 32-bit operand right by an amount taken from a register, or turns it right by one position through the carry flag (the extended rotate, a 33-bit rotation). Alongside the rotated value it produces the new carry value and a flag that says whether that carry should be written back.

Rotate amounts are eight bits wide. An amount of 32 or more is reduced by 32 over and over until it falls in the range 1 to 32. An amount of exactly 32 therefore leaves the operand unchanged, but it still produces a carry. An amount of zero changes nothing, including the carry. The carry is reported as valid only when the caller asks for a flag update. When it is not valid, the unit passes the incoming carry through, so the flag keeps its old value.

With the default `REG_OUT = 1` the outputs are registered once. Setting `REG_OUT = 0` makes the stage purely combinational.

Top module: `rot_carry_unit`

## Requirements
- R1: With op_ext_i = 0 and an amount whose low five bits are 1 to 31, result_o is the operand rotated right by that many positions. Bit k of the result is operand bit (k + n) mod 32.
- R2: For a rotate with a nonzero amount and flag_upd_i = 1, carry_vld_o = 1 and carry_o equals bit 31 of result_o. This is the last bit that left position 0.
- R3: An amount of 32 (and any nonzero multiple of 32, such as 64, 96 or 224) returns the operand unchanged. With a flag update, carry_o is operand bit 31.
- R4: An amount greater than 32 gives the same result and carry as that amount minus 32, applied repeatedly (33 acts as 1, 63 as 31, 255 as 31).
- R5: An amount of 0 with op_ext_i = 0 returns the operand unchanged, forces carry_vld_o = 0 and passes carry_i to carry_o, even when flag_upd_i = 1.
- R6: With op_ext_i = 1, result_o is {carry_i, operand_i[31:1]}, and the amount has no effect.
- R7: With op_ext_i = 1 and flag_upd_i = 1, carry_vld_o = 1 and carry_o is operand_i[0].
- R8: With flag_upd_i = 0, carry_vld_o = 0 and carry_o equals carry_i, whatever the operation.
- R9: With REG_OUT = 1, the outputs reflect the inputs sampled at the previous rising clock edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand_i | input | 32 | Value to rotate |
| amount_i | input | 8 | Rotate amount for the register-amount rotate |
| op_ext_i | input | 1 | 0 = rotate by amount, 1 = rotate right by one through carry |
| carry_i | input | 1 | Incoming carry flag |
| flag_upd_i | input | 1 | Request to update the carry flag |
| result_o | output | 32 | Rotated value |
| carry_o | output | 1 | New carry, or carry_i passed through when not valid |
| carry_vld_o | output | 1 | Carry write-back enable |

## Verification
Every result, carry and valid bit is due exactly one rising edge after the inputs are presented, because the default build has one output register and no other state. The bench changes inputs on the falling edge and compares all three outputs shortly after the following rising edge, before it applies the next vector. This gives one complete vector per cycle with no overlap. It sweeps all 256 amounts for both operations, both carry values and both update settings, over fixed and random operands, against a reference model that reduces the amount by repeated subtraction.

// File: rtl/rot_carry_unit.sv
module rot_carry_unit #(
  parameter int W       = 32,
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     operand_i,
  input  logic [AMT_W-1:0] amount_i,
  input  logic             op_ext_i,
  input  logic             carry_i,
  input  logic             flag_upd_i,
  output logic [W-1:0]     result_o,
  output logic             carry_o,
  output logic             carry_vld_o
);
  localparam int SH = $clog2(W);

  logic [SH-1:0]  rot_low;
  logic           amt_zero;
  logic [2*W-1:0] dbl;
  logic [W-1:0]   rot_res;
  logic [W-1:0]   ext_res;
  logic [W-1:0]   nxt_res;
  logic           nxt_vld;
  logic           nxt_c;

  // amounts reduce modulo W; a zero remainder of a nonzero amount is a full turn
  assign rot_low  = amount_i[SH-1:0];
  assign amt_zero = (amount_i == '0);
  assign dbl      = {operand_i, operand_i} >> rot_low;
  assign rot_res  = dbl[W-1:0];
  assign ext_res  = {carry_i, operand_i[W-1:1]};

  assign nxt_res = op_ext_i ? ext_res : rot_res;
  assign nxt_vld = flag_upd_i & (op_ext_i | ~amt_zero);
  assign nxt_c   = !nxt_vld ? carry_i
                 : (op_ext_i ? operand_i[0] : rot_res[W-1]);

  generate
    if (REG_OUT) begin : g_reg
      logic armed_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result_o    <= '0;
          carry_o     <= 1'b0;
          carry_vld_o <= 1'b0;
          armed_q     <= 1'b0;
        end else begin
          result_o    <= nxt_res;
          carry_o     <= nxt_c;
          carry_vld_o <= nxt_vld;
          armed_q     <= 1'b1;
        end
      end

      a_r5_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(!op_ext_i && amount_i == '0)
        |-> result_o == $past(operand_i) && !carry_vld_o);

      a_r8_hold_carry: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(flag_upd_i)
        |-> !carry_vld_o && carry_o == $past(carry_i));

      a_r7_ext_carry: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_ext_i && flag_upd_i)
        |-> carry_vld_o && carry_o == $past(operand_i[0]));

      a_r6_ext_result: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_ext_i)
        |-> result_o == {$past(carry_i), $past(operand_i[W-1:1])});

      a_r3_full_turn: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(!op_ext_i && amount_i != '0 && amount_i[SH-1:0] == '0)
        |-> result_o == $past(operand_i));

      a_r2_carry_msb: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && carry_vld_o && !$past(op_ext_i)
        |-> carry_o == result_o[W-1]);
    end else begin : g_comb
      assign result_o    = nxt_res;
      assign carry_o     = nxt_c;
      assign carry_vld_o = nxt_vld;

      a_r8_hold_carry: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_upd_i |-> !carry_vld_o && carry_o == carry_i);

      a_r6_ext_result: assert property (@(posedge clk) disable iff (!rst_n)
        op_ext_i |-> result_o == {carry_i, operand_i[W-1:1]});
    end
  endgenerate
endmodule

// File: tb/tb_rot_carry_unit.sv
`timescale 1ns/1ps
module tb_rot_carry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] operand_i = '0;
  logic [7:0]  amount_i = '0;
  logic        op_ext_i = 1'b0;
  logic        carry_i = 1'b0;
  logic        flag_upd_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;
  logic        carry_vld_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rot_carry_unit dut (
    .clk(clk), .rst_n(rst_n), .operand_i(operand_i), .amount_i(amount_i),
    .op_ext_i(op_ext_i), .carry_i(carry_i), .flag_upd_i(flag_upd_i),
    .result_o(result_o), .carry_o(carry_o), .carry_vld_o(carry_vld_o)
  );

  function automatic string req_of(input logic ext, input logic [7:0] a, input logic upd);
    if (ext) return upd ? "R7" : "R6";
    if (!upd) return "R8";
    if (a == 0) return "R5";
    if (a == 32 || a == 64 || a == 96 || a == 128 || a == 160 || a == 192 || a == 224) return "R3";
    if (a > 32) return "R4";
    return (a[0]) ? "R1" : "R2";
  endfunction

  task automatic apply_check(input logic [31:0] op, input logic [7:0] a,
                             input logic ext, input logic c, input logic upd);
    int eff;
    logic [31:0] e_res;
    logic e_c, e_v;
    @(negedge clk);
    operand_i = op; amount_i = a; op_ext_i = ext; carry_i = c; flag_upd_i = upd;
    if (ext) begin
      e_res = {c, op[31:1]};
      e_v = upd;
      e_c = upd ? op[0] : c;
    end else begin
      eff = int'(a);
      while (eff > 32) eff = eff - 32;
      e_res = op;
      for (int i = 0; i < eff; i++) e_res = {e_res[0], e_res[31:1]};
      e_v = upd && (eff != 0);
      e_c = e_v ? ((eff == 32) ? op[31] : e_res[31]) : c;
    end
    @(posedge clk);
    #1;
    n_run++;
    if (result_o !== e_res || carry_o !== e_c || carry_vld_o !== e_v) begin
      n_fail++;
      $display("FAIL %s (R9 timing) op=%h amt=%0d ext=%b c=%b upd=%b: got res=%h c=%b v=%b exp res=%h c=%b v=%b",
               req_of(ext, a, upd), op, a, ext, c, upd, result_o, carry_o, carry_vld_o, e_res, e_c, e_v);
    end
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] ops [8];
    ops[0] = 32'h8000_0001; ops[1] = 32'h0000_0001; ops[2] = 32'h8000_0000;
    ops[3] = 32'hFFFF_FFFF; ops[4] = 32'h0000_0000; ops[5] = 32'h1234_5678;
    ops[6] = $urandom(7);   ops[7] = $urandom;
    operand_i = 32'hDEAD_BEEF; flag_upd_i = 1'b1; carry_i = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (result_o !== '0 || carry_o !== 1'b0 || carry_vld_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 reset: got res=%h c=%b v=%b exp 0 0 0", result_o, carry_o, carry_vld_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 256; a++)
        for (int m = 0; m < 8; m++)
          apply_check(ops[k], a[7:0], m[2], m[1], m[0]);
    for (int r = 0; r < 400; r++) begin
      logic [31:0] rop;
      rop = $urandom;
      apply_check(rop, 8'd0,   1'b0, r[0], 1'b1);
      apply_check(rop, 8'd1,   1'b0, r[1], 1'b1);
      apply_check(rop, 8'd31,  1'b0, r[0], 1'b1);
      apply_check(rop, 8'd32,  1'b0, r[1], 1'b1);
      apply_check(rop, 8'd33,  1'b0, r[0], 1'b1);
      apply_check(rop, 8'd63,  1'b0, r[1], 1'b1);
      apply_check(rop, 8'd64,  1'b0, r[0], 1'b1);
      apply_check(rop, 8'd255, 1'b0, r[1], 1'b1);
      apply_check(rop, 8'(r),  1'b1, r[2], 1'b1);
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule